// File: doc/BRIEF.md
# Machine-Mode Trap and CSR Unit

This unit holds the machine-level control and status registers of a small 32-bit RISC-V core. It serves one CSR access per cycle: the old register value is returned combinationally, and the modified value is written at the next clock edge. The operand is either the rs1 register value or the zero-extended 5-bit immediate. The unit also reads a constant ISA word, a constant vendor word and the low word of a free-running cycle counter.

The same unit takes exceptions and interrupts, ECALL, EBREAK and unknown SYSTEM encodings, and the return-from-trap strobe. In the cycle of any of these events it raises a redirect with the target pc. At the next edge it updates the status, cause, trap-value and exception-pc registers and the privilege level. The pipeline uses the write-enable output to decide whether the destination register of a CSR instruction may be written.

Top module: `mtcsr_unit`

## Requirements
- R1: After reset the privilege output is machine (2'b11), and every writable CSR (0x300, 0x304, 0x305, 0x340, 0x341, 0x342, 0x343, 0x344) reads zero.
- R2: A CSR access returns the register's value from before the access on `csr_rdata_o` in the same cycle. Its new value is visible from the next cycle.
- R3: Address 0x301 reads 0x40401101 and address 0xF11 reads 0xFF0FF0FF. Writes to these addresses, to 0xC00 and to unimplemented addresses are ignored. Unimplemented addresses read zero and raise no trap.
- R4: An access with `csr_op_i` 1 writes rs1, with 2 sets the rs1 bits, and with 3 clears the rs1 bits.
- R5: Operation codes 5, 6 and 7 behave as 1, 2 and 3, using the zero-extended `csr_uimm_i` as the operand.
- R6: Operation codes 0 and 4 are illegal. They redirect to mtvec, record cause 2, give `rd_en_o` low, and leave the addressed CSR unchanged.
- R7: On trap entry, the following happens:
  - mstatus becomes: bit 7 = old bit 3, bits 12:11 = old privilege, all other bits 0.
  - The privilege becomes 3.
  - `redirect_pc_o` equals mtvec in the same cycle.
- R8: For an exception, mcause (0x342) is the cause code and mepc (0x341) is `pc_i`. mtval (0x343) is `trap_addr_i` for causes 5, 6 and 7, and `pc_i` for any other cause.
- R9: For an interrupt, mcause is the cause code with bit 31 set, mtval is 0, and mepc is `pc_i`, the pc of the next instruction.
- R10: The return-from-trap strobe does the following:
  - Redirects to mepc.
  - Sets mstatus bit 3 from bit 7, sets bit 7 to 1 and sets bits 12:11 to 0.
  - Restores the privilege from the old bits 12:11.
- R11: A SYSTEM request with code 0x000 traps with cause 11 in machine mode and cause 8 in user mode. Code 0x001 traps with cause 3. Any other code traps with cause 2.
- R12: `rd_en_o` is high only for a legal CSR access in a cycle with no trap. It is low whenever a trap is taken.
- R13: Address 0xC00 reads a counter that rises by one on every clock edge after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| csr_req_i | input | 1 | CSR access valid |
| csr_addr_i | input | 12 | CSR address |
| csr_op_i | input | 3 | Operation code (funct3) |
| csr_rs1_i | input | 32 | rs1 register value |
| csr_uimm_i | input | 5 | 5-bit immediate operand |
| csr_rdata_o | output | 32 | Old value of the addressed CSR |
| rd_en_o | output | 1 | Destination register may be written |
| trap_req_i | input | 1 | Exception or interrupt request |
| trap_irq_i | input | 1 | Request is an interrupt |
| trap_cause_i | input | 5 | Cause code |
| trap_addr_i | input | 32 | Faulting data address |
| sys_req_i | input | 1 | SYSTEM instruction (non-CSR) valid |
| sys_code_i | input | 12 | SYSTEM function code |
| mret_i | input | 1 | Return-from-trap strobe |
| pc_i | input | 32 | pc of the current (or, for an interrupt, next) instruction |
| redirect_o | output | 1 | Fetch must redirect |
| redirect_pc_o | output | 32 | Redirect target |
| priv_o | output | 2 | Current privilege: 0 user, 3 machine |

## Verification
A wrong status or privilege register is hidden until the next trap or return. It then shows as a wrong saved MPP or MPIE, as a wrong cause code for ECALL (8 instead of 11), or as a wrong privilege on `priv_o` one cycle after the return. A corrupted cause, trap-value or exception-pc register shows on the next CSR read of that address, one cycle after the trap, and a wrong return target shows at once on `redirect_pc_o`. For this reason the bench reads the trap registers back right after every trap, and runs a return into user mode followed by an ECALL so that the saved privilege travels through both paths.

// File: rtl/mtcsr_pkg.sv
package mtcsr_pkg;
  localparam int XLEN = 32;

  localparam logic [11:0] A_MSTATUS  = 12'h300;
  localparam logic [11:0] A_MISA     = 12'h301;
  localparam logic [11:0] A_MIE      = 12'h304;
  localparam logic [11:0] A_MTVEC    = 12'h305;
  localparam logic [11:0] A_MSCRATCH = 12'h340;
  localparam logic [11:0] A_MEPC     = 12'h341;
  localparam logic [11:0] A_MCAUSE   = 12'h342;
  localparam logic [11:0] A_MTVAL    = 12'h343;
  localparam logic [11:0] A_MIP      = 12'h344;
  localparam logic [11:0] A_CYCLE    = 12'hC00;
  localparam logic [11:0] A_VENDOR   = 12'hF11;

  localparam logic [XLEN-1:0] ISA_WORD    = 32'h4040_1101;
  localparam logic [XLEN-1:0] VENDOR_WORD = 32'hFF0F_F0FF;

  localparam int IE_BIT   = 3;
  localparam int PIE_BIT  = 7;
  localparam int PP_LO    = 11;
  localparam int PP_HI    = 12;

  localparam logic [1:0] PRIV_USER    = 2'b00;
  localparam logic [1:0] PRIV_MACHINE = 2'b11;

  typedef enum logic [1:0] {
    OPK_NONE  = 2'b00,
    OPK_WRITE = 2'b01,
    OPK_SET   = 2'b10,
    OPK_CLEAR = 2'b11
  } op_kind_e;

  localparam logic [11:0] SYS_ENV_CALL = 12'h000;
  localparam logic [11:0] SYS_BREAK    = 12'h001;

  localparam logic [4:0] CAUSE_ILLEGAL = 5'd2;
  localparam logic [4:0] CAUSE_BREAK   = 5'd3;
  localparam logic [4:0] CAUSE_ECALL_U = 5'd8;
  localparam logic [4:0] CAUSE_ECALL_M = 5'd11;
endpackage

// File: rtl/mtcsr_wdata.sv
module mtcsr_wdata
  import mtcsr_pkg::*;
#(
  parameter int W      = 32,
  parameter int UIMM_W = 5
) (
  input  logic [2:0]        op_i,
  input  logic [W-1:0]      old_i,
  input  logic [W-1:0]      rs1_i,
  input  logic [UIMM_W-1:0] uimm_i,
  output logic [W-1:0]      wdata_o,
  output logic              illegal_o
);
  logic [W-1:0] src;
  op_kind_e     kind;

  assign src  = op_i[2] ? W'(uimm_i) : rs1_i;
  assign kind = op_kind_e'(op_i[1:0]);

  always_comb begin
    illegal_o = 1'b0;
    unique case (kind)
      OPK_WRITE: wdata_o = src;
      OPK_SET:   wdata_o = old_i | src;
      OPK_CLEAR: wdata_o = old_i & ~src;
      default: begin
        wdata_o   = old_i;
        illegal_o = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/mtcsr_trap_ctl.sv
module mtcsr_trap_ctl
  import mtcsr_pkg::*;
#(
  parameter int W       = 32,
  parameter int CAUSE_W = 5
) (
  input  logic [W-1:0]       mstatus_i,
  input  logic [1:0]         priv_i,
  input  logic               irq_i,
  input  logic [CAUSE_W-1:0] cause_i,
  input  logic [W-1:0]       addr_i,
  input  logic [W-1:0]       pc_i,
  output logic [W-1:0]       trap_mstatus_o,
  output logic [W-1:0]       trap_mcause_o,
  output logic [W-1:0]       trap_mtval_o,
  output logic [W-1:0]       ret_mstatus_o,
  output logic [1:0]         ret_priv_o
);
  localparam int PAD_W = W - 1 - CAUSE_W;

  logic data_fault;
  assign data_fault = (cause_i >= CAUSE_W'(5)) && (cause_i <= CAUSE_W'(7));

  always_comb begin
    trap_mstatus_o                 = '0;
    trap_mstatus_o[PIE_BIT]        = mstatus_i[IE_BIT];
    trap_mstatus_o[PP_HI:PP_LO]    = priv_i;
    trap_mcause_o                  = {irq_i, {PAD_W{1'b0}}, cause_i};
    if (irq_i)           trap_mtval_o = '0;
    else if (data_fault) trap_mtval_o = addr_i;
    else                 trap_mtval_o = pc_i;
  end

  always_comb begin
    ret_mstatus_o          = '0;
    ret_mstatus_o[IE_BIT]  = mstatus_i[PIE_BIT];
    ret_mstatus_o[PIE_BIT] = 1'b1;
    ret_priv_o             = mstatus_i[PP_HI:PP_LO];
  end
endmodule

// File: rtl/mtcsr_cycle_ctr.sv
module mtcsr_cycle_ctr #(
  parameter int CNT_W = 64,
  parameter int OUT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [OUT_W-1:0] low_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + CNT_W'(1);
  end

  assign low_o = cnt_q[OUT_W-1:0];

  a_r13_cycle_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> cnt_q == $past(cnt_q) + CNT_W'(1));
endmodule

// File: rtl/mtcsr_unit.sv
module mtcsr_unit
  import mtcsr_pkg::*;
#(
  parameter int CAUSE_W = 5,
  parameter int UIMM_W  = 5,
  parameter int CYC_W   = 64
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                csr_req_i,
  input  logic [11:0]         csr_addr_i,
  input  logic [2:0]          csr_op_i,
  input  logic [XLEN-1:0]     csr_rs1_i,
  input  logic [UIMM_W-1:0]   csr_uimm_i,
  output logic [XLEN-1:0]     csr_rdata_o,
  output logic                rd_en_o,
  input  logic                trap_req_i,
  input  logic                trap_irq_i,
  input  logic [CAUSE_W-1:0]  trap_cause_i,
  input  logic [XLEN-1:0]     trap_addr_i,
  input  logic                sys_req_i,
  input  logic [11:0]         sys_code_i,
  input  logic                mret_i,
  input  logic [XLEN-1:0]     pc_i,
  output logic                redirect_o,
  output logic [XLEN-1:0]     redirect_pc_o,
  output logic [1:0]          priv_o
);
  logic [XLEN-1:0] mstatus_q, mie_q, mtvec_q, mscratch_q;
  logic [XLEN-1:0] mepc_q, mcause_q, mtval_q, mip_q;
  logic [1:0]      priv_q;
  logic [XLEN-1:0] cycle_lo;

  logic [XLEN-1:0] old_val, wdata;
  logic            op_illegal;

  // read mux
  always_comb begin
    unique case (csr_addr_i)
      A_MSTATUS:  old_val = mstatus_q;
      A_MISA:     old_val = ISA_WORD;
      A_MIE:      old_val = mie_q;
      A_MTVEC:    old_val = mtvec_q;
      A_MSCRATCH: old_val = mscratch_q;
      A_MEPC:     old_val = mepc_q;
      A_MCAUSE:   old_val = mcause_q;
      A_MTVAL:    old_val = mtval_q;
      A_MIP:      old_val = mip_q;
      A_CYCLE:    old_val = cycle_lo;
      A_VENDOR:   old_val = VENDOR_WORD;
      default:    old_val = '0;
    endcase
  end
  assign csr_rdata_o = old_val;

  mtcsr_wdata #(.W(XLEN), .UIMM_W(UIMM_W)) u_wdata (
    .op_i      (csr_op_i),
    .old_i     (old_val),
    .rs1_i     (csr_rs1_i),
    .uimm_i    (csr_uimm_i),
    .wdata_o   (wdata),
    .illegal_o (op_illegal)
  );

  // trap source priority: external request, SYSTEM, illegal CSR op
  logic               take_trap, ret_taken, csr_we;
  logic               exc_irq;
  logic [CAUSE_W-1:0] exc_cause, sys_cause;
  logic [XLEN-1:0]    exc_addr;

  always_comb begin
    if (sys_code_i == SYS_ENV_CALL)
      sys_cause = (priv_q == PRIV_MACHINE) ? CAUSE_W'(CAUSE_ECALL_M) : CAUSE_W'(CAUSE_ECALL_U);
    else if (sys_code_i == SYS_BREAK)
      sys_cause = CAUSE_W'(CAUSE_BREAK);
    else
      sys_cause = CAUSE_W'(CAUSE_ILLEGAL);
  end

  always_comb begin
    exc_irq   = 1'b0;
    exc_addr  = '0;
    exc_cause = CAUSE_W'(CAUSE_ILLEGAL);
    if (trap_req_i) begin
      exc_irq   = trap_irq_i;
      exc_cause = trap_cause_i;
      exc_addr  = trap_addr_i;
    end else if (sys_req_i) begin
      exc_cause = sys_cause;
    end
  end

  assign take_trap = trap_req_i | sys_req_i | (csr_req_i & op_illegal);
  assign ret_taken = mret_i & ~take_trap;
  assign csr_we    = csr_req_i & ~take_trap & ~mret_i;
  assign rd_en_o   = csr_req_i & ~take_trap;

  logic [XLEN-1:0] trap_mstatus, trap_mcause, trap_mtval, ret_mstatus;
  logic [1:0]      ret_priv;

  mtcsr_trap_ctl #(.W(XLEN), .CAUSE_W(CAUSE_W)) u_trap_ctl (
    .mstatus_i      (mstatus_q),
    .priv_i         (priv_q),
    .irq_i          (exc_irq),
    .cause_i        (exc_cause),
    .addr_i         (exc_addr),
    .pc_i           (pc_i),
    .trap_mstatus_o (trap_mstatus),
    .trap_mcause_o  (trap_mcause),
    .trap_mtval_o   (trap_mtval),
    .ret_mstatus_o  (ret_mstatus),
    .ret_priv_o     (ret_priv)
  );

  mtcsr_cycle_ctr #(.CNT_W(CYC_W), .OUT_W(XLEN)) u_cycle (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .low_o  (cycle_lo)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mstatus_q  <= '0;
      mie_q      <= '0;
      mtvec_q    <= '0;
      mscratch_q <= '0;
      mepc_q     <= '0;
      mcause_q   <= '0;
      mtval_q    <= '0;
      mip_q      <= '0;
      priv_q     <= PRIV_MACHINE;
    end else if (take_trap) begin
      mstatus_q <= trap_mstatus;
      mcause_q  <= trap_mcause;
      mtval_q   <= trap_mtval;
      mepc_q    <= pc_i;
      priv_q    <= PRIV_MACHINE;
    end else if (ret_taken) begin
      mstatus_q <= ret_mstatus;
      priv_q    <= ret_priv;
    end else if (csr_we) begin
      unique case (csr_addr_i)
        A_MSTATUS:  mstatus_q  <= wdata;
        A_MIE:      mie_q      <= wdata;
        A_MTVEC:    mtvec_q    <= wdata;
        A_MSCRATCH: mscratch_q <= wdata;
        A_MEPC:     mepc_q     <= wdata;
        A_MCAUSE:   mcause_q   <= wdata;
        A_MTVAL:    mtval_q    <= wdata;
        A_MIP:      mip_q      <= wdata;
        default: ;
      endcase
    end
  end

  assign redirect_o    = take_trap | ret_taken;
  assign redirect_pc_o = take_trap ? mtvec_q : mepc_q;
  assign priv_o        = priv_q;

  a_r7_priv_machine: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_trap |=> priv_o == PRIV_MACHINE);
  a_r7_status_save: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_trap |=> !mstatus_q[IE_BIT] && mstatus_q[PIE_BIT] == $past(mstatus_q[IE_BIT])
                  && mstatus_q[PP_HI:PP_LO] == $past(priv_q));
  a_r10_ret_restore: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_taken |=> mstatus_q[PIE_BIT] && mstatus_q[PP_HI:PP_LO] == 2'b00
                  && priv_o == $past(mstatus_q[PP_HI:PP_LO]));
  a_r6_illegal_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csr_req_i && csr_op_i[1:0] == 2'b00 && !trap_req_i && !sys_req_i
      |=> mcause_q == XLEN'(CAUSE_ILLEGAL));
  a_r12_no_rd_on_trap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_req_i || sys_req_i) |-> !rd_en_o);
  a_r3_const_reads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csr_addr_i == A_MISA |-> csr_rdata_o == ISA_WORD);
endmodule

// File: tb/mtcsr_unit_bench.sv
module mtcsr_unit_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        csr_req, trap_req, trap_irq, sys_req, mret;
  logic [11:0] csr_addr, sys_code;
  logic [2:0]  csr_op;
  logic [31:0] csr_rs1, trap_addr, pc;
  logic [4:0]  csr_uimm, trap_cause;
  logic [31:0] csr_rdata, redirect_pc;
  logic        rd_en, redirect;
  logic [1:0]  priv;

  mtcsr_unit u_mtcsr_unit (
    .clk_i(clk), .rst_ni(rst_n),
    .csr_req_i(csr_req), .csr_addr_i(csr_addr), .csr_op_i(csr_op),
    .csr_rs1_i(csr_rs1), .csr_uimm_i(csr_uimm), .csr_rdata_o(csr_rdata),
    .rd_en_o(rd_en), .trap_req_i(trap_req), .trap_irq_i(trap_irq),
    .trap_cause_i(trap_cause), .trap_addr_i(trap_addr), .sys_req_i(sys_req),
    .sys_code_i(sys_code), .mret_i(mret), .pc_i(pc),
    .redirect_o(redirect), .redirect_pc_o(redirect_pc), .priv_o(priv)
  );

  typedef struct {
    string       tag;
    logic [31:0] rdata;
    logic        chk_rdata;
    logic        rd_en;
    logic        redir;
    logic [31:0] tgt;
    logic [1:0]  priv;
    logic        is_cyc;
  } exp_t;

  exp_t        sb_q[$];
  logic [31:0] cyc_seen[$];
  int vectors = 0, miscompares = 0;
  bit done = 0;

  // reference state
  logic [31:0] m_mstatus, m_mie, m_mtvec, m_mscratch, m_mepc, m_mcause, m_mtval, m_mip;
  logic [1:0]  m_priv;

  function automatic logic [31:0] ref_read(logic [11:0] a);
    case (a)
      12'h300: return m_mstatus;
      12'h301: return 32'h4040_1101;
      12'h304: return m_mie;
      12'h305: return m_mtvec;
      12'h340: return m_mscratch;
      12'h341: return m_mepc;
      12'h342: return m_mcause;
      12'h343: return m_mtval;
      12'h344: return m_mip;
      12'hF11: return 32'hFF0F_F0FF;
      default: return 32'h0;
    endcase
  endfunction

  task automatic ref_write(logic [11:0] a, logic [31:0] v);
    case (a)
      12'h300: m_mstatus  = v;
      12'h304: m_mie      = v;
      12'h305: m_mtvec    = v;
      12'h340: m_mscratch = v;
      12'h341: m_mepc     = v;
      12'h342: m_mcause   = v;
      12'h343: m_mtval    = v;
      12'h344: m_mip      = v;
      default: ;
    endcase
  endtask

  task automatic ref_trap(logic irq, logic [4:0] c, logic [31:0] a, logic [31:0] p);
    m_mcause  = irq ? {1'b1, 26'b0, c} : {27'b0, c};
    m_mtval   = irq ? 32'h0 : ((c >= 5 && c <= 7) ? a : p);
    m_mepc    = p;
    m_mstatus = {19'b0, m_priv, 3'b0, m_mstatus[3], 7'b0};
    m_priv    = 2'b11;
  endtask

  task automatic clear_in();
    csr_req = 0; trap_req = 0; trap_irq = 0; sys_req = 0; mret = 0;
    csr_addr = 0; sys_code = 0; csr_op = 0; csr_rs1 = 0; trap_addr = 0;
    pc = 0; csr_uimm = 0; trap_cause = 0;
  endtask

  task automatic idle();
    @(negedge clk); clear_in();
  endtask

  task automatic do_csr(string tag, logic [2:0] op, logic [11:0] a,
                        logic [31:0] rs1, logic [4:0] u, logic [31:0] p);
    exp_t e;
    logic [31:0] old, src, nv;
    logic bad;
    @(negedge clk); clear_in();
    csr_req = 1; csr_op = op; csr_addr = a; csr_rs1 = rs1; csr_uimm = u; pc = p;
    old = ref_read(a);
    src = op[2] ? {27'b0, u} : rs1;
    bad = (op[1:0] == 2'b00);
    case (op[1:0])
      2'b01: nv = src;
      2'b10: nv = old | src;
      default: nv = old & ~src;
    endcase
    e.tag = tag; e.rdata = old; e.chk_rdata = 1; e.rd_en = !bad; e.redir = bad;
    e.tgt = m_mtvec; e.priv = m_priv; e.is_cyc = (a == 12'hC00);
    sb_q.push_back(e);
    if (bad) ref_trap(1'b0, 5'd2, 32'h0, p);
    else     ref_write(a, nv);
  endtask

  task automatic do_trap(string tag, logic irq, logic [4:0] c, logic [31:0] a, logic [31:0] p);
    exp_t e;
    @(negedge clk); clear_in();
    trap_req = 1; trap_irq = irq; trap_cause = c; trap_addr = a; pc = p;
    e.tag = tag; e.rdata = 0; e.chk_rdata = 0; e.rd_en = 0; e.redir = 1;
    e.tgt = m_mtvec; e.priv = m_priv; e.is_cyc = 0;
    sb_q.push_back(e);
    ref_trap(irq, c, a, p);
  endtask

  task automatic do_sys(string tag, logic [11:0] code, logic [31:0] p);
    exp_t e;
    logic [4:0] c;
    @(negedge clk); clear_in();
    sys_req = 1; sys_code = code; pc = p;
    if (code == 12'h000)      c = (m_priv == 2'b11) ? 5'd11 : 5'd8;
    else if (code == 12'h001) c = 5'd3;
    else                      c = 5'd2;
    e.tag = tag; e.rdata = 0; e.chk_rdata = 0; e.rd_en = 0; e.redir = 1;
    e.tgt = m_mtvec; e.priv = m_priv; e.is_cyc = 0;
    sb_q.push_back(e);
    ref_trap(1'b0, c, 32'h0, p);
  endtask

  task automatic do_mret(string tag);
    exp_t e;
    @(negedge clk); clear_in();
    mret = 1;
    e.tag = tag; e.rdata = 0; e.chk_rdata = 0; e.rd_en = 0; e.redir = 1;
    e.tgt = m_mepc; e.priv = m_priv; e.is_cyc = 0;
    sb_q.push_back(e);
    m_priv    = m_mstatus[12:11];
    m_mstatus = {19'b0, 2'b00, 3'b0, 1'b1, 3'b0, m_mstatus[7], 3'b0};
  endtask

  task automatic fail_line(string tag, string what, logic [31:0] act, logic [31:0] exp);
    miscompares++;
    $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk); #1;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        vectors++;
        if (e.is_cyc) cyc_seen.push_back(csr_rdata);
        else if (e.chk_rdata && csr_rdata !== e.rdata) fail_line(e.tag, "rdata", csr_rdata, e.rdata);
        if (rd_en !== e.rd_en) fail_line(e.tag, "rd_en", {31'b0, rd_en}, {31'b0, e.rd_en});
        if (redirect !== e.redir) fail_line(e.tag, "redirect", {31'b0, redirect}, {31'b0, e.redir});
        if (e.redir && redirect_pc !== e.tgt) fail_line(e.tag, "target", redirect_pc, e.tgt);
        if (priv !== e.priv) fail_line(e.tag, "priv", {30'b0, priv}, {30'b0, e.priv});
      end
    end
  end

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: run did not complete");
      summary();
      $finish;
    end
  end

  initial begin
    clear_in();
    m_mstatus = 0; m_mie = 0; m_mtvec = 0; m_mscratch = 0;
    m_mepc = 0; m_mcause = 0; m_mtval = 0; m_mip = 0; m_priv = 2'b11;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state, read with set-by-zero immediate
    do_csr("R1 mstatus", 3'd6, 12'h300, 0, 0, 32'h100);
    do_csr("R1 mie",     3'd6, 12'h304, 0, 0, 32'h104);
    do_csr("R1 mtvec",   3'd6, 12'h305, 0, 0, 32'h108);
    do_csr("R1 mepc",    3'd6, 12'h341, 0, 0, 32'h10C);
    do_csr("R1 mcause",  3'd6, 12'h342, 0, 0, 32'h110);
    do_csr("R1 mip",     3'd6, 12'h344, 0, 0, 32'h114);
    // R3 constants and ignored writes
    do_csr("R3 misa",      3'd1, 12'h301, 32'h0, 0, 32'h118);
    do_csr("R3 misa kept", 3'd2, 12'h301, 32'h0, 0, 32'h11C);
    do_csr("R3 vendor",    3'd1, 12'hF11, 32'h1, 0, 32'h120);
    do_csr("R3 vendor kept", 3'd2, 12'hF11, 32'h0, 0, 32'h124);
    do_csr("R3 unimpl write", 3'd1, 12'h7C0, 32'hFFFF_FFFF, 0, 32'h128);
    do_csr("R3 unimpl read",  3'd2, 12'h7C0, 32'h0, 0, 32'h12C);
    // R2 R4 register ops
    do_csr("R4 write",  3'd1, 12'h340, 32'hDEAD_BEEF, 0, 32'h130);
    do_csr("R2 R4 set", 3'd2, 12'h340, 32'h0000_00F0, 0, 32'h134);
    do_csr("R4 clear",  3'd3, 12'h340, 32'h0000_00FF, 0, 32'h138);
    do_csr("R2 readback", 3'd2, 12'h340, 32'h0, 0, 32'h13C);
    // R5 immediate forms
    do_csr("R5 writei", 3'd5, 12'h344, 32'hFFFF_FFFF, 5'h1F, 32'h140);
    do_csr("R5 seti",   3'd6, 12'h344, 32'hFFFF_FFFF, 5'h10, 32'h144);
    do_csr("R5 cleari", 3'd7, 12'h344, 32'hFFFF_FFFF, 5'h03, 32'h148);
    do_csr("R5 readback", 3'd6, 12'h344, 32'h0, 0, 32'h14C);
    do_csr("R4 mtvec",  3'd1, 12'h305, 32'h8000_0100, 0, 32'h150);
    do_csr("R4 mie",    3'd1, 12'h304, 32'h0000_0080, 0, 32'h154);
    // R6 illegal ops
    do_csr("R6 op4",    3'd4, 12'h340, 32'h1234_5678, 0, 32'h158);
    do_csr("R6 kept",   3'd2, 12'h340, 32'h0, 0, 32'h15C);
    do_csr("R6 cause",  3'd2, 12'h342, 32'h0, 0, 32'h160);
    do_csr("R6 tval",   3'd2, 12'h343, 32'h0, 0, 32'h164);
    do_csr("R6 op0",    3'd0, 12'h304, 32'hFFFF_FFFF, 0, 32'h168);
    do_csr("R6 mie kept", 3'd2, 12'h304, 32'h0, 0, 32'h16C);
    // R7 R8 exception with interrupts enabled
    do_csr("R4 mstatus", 3'd1, 12'h300, 32'h0000_0008, 0, 32'h170);
    do_trap("R7 R8 load fault", 1'b0, 5'd5, 32'h0000_1234, 32'h8000_0040);
    do_csr("R7 mstatus", 3'd2, 12'h300, 32'h0, 0, 32'h8000_0100);
    do_csr("R8 mcause",  3'd2, 12'h342, 32'h0, 0, 32'h8000_0104);
    do_csr("R8 mtval addr", 3'd2, 12'h343, 32'h0, 0, 32'h8000_0108);
    do_csr("R8 mepc",    3'd2, 12'h341, 32'h0, 0, 32'h8000_010C);
    do_trap("R8 store fault", 1'b0, 5'd7, 32'hABCD_0000, 32'h8000_0050);
    do_csr("R8 mtval c7", 3'd2, 12'h343, 32'h0, 0, 32'h8000_0110);
    do_trap("R8 other cause", 1'b0, 5'd4, 32'hABCD_0000, 32'h8000_0060);
    do_csr("R8 mtval pc", 3'd2, 12'h343, 32'h0, 0, 32'h8000_0114);
    // R9 interrupt
    do_trap("R9 irq", 1'b1, 5'd7, 32'h5555_5555, 32'h8000_0070);
    do_csr("R9 mcause", 3'd2, 12'h342, 32'h0, 0, 32'h8000_0118);
    do_csr("R9 mtval",  3'd2, 12'h343, 32'h0, 0, 32'h8000_011C);
    do_csr("R9 mepc",   3'd2, 12'h341, 32'h0, 0, 32'h8000_0120);
    // R10 return to user, then R11 ECALL from user
    do_csr("R4 mstatus pp0", 3'd1, 12'h300, 32'h0000_0080, 0, 32'h8000_0124);
    do_csr("R4 mepc", 3'd1, 12'h341, 32'h8000_2000, 0, 32'h8000_0128);
    do_mret("R10 mret");
    do_csr("R10 mstatus", 3'd2, 12'h300, 32'h0, 0, 32'h8000_2000);
    do_sys("R11 ecall user", 12'h000, 32'h8000_2004);
    do_csr("R11 cause8", 3'd2, 12'h342, 32'h0, 0, 32'h8000_0100);
    do_csr("R7 mstatus from user", 3'd2, 12'h300, 32'h0, 0, 32'h8000_0104);
    do_sys("R11 ecall machine", 12'h000, 32'h8000_0108);
    do_csr("R11 cause11", 3'd2, 12'h342, 32'h0, 0, 32'h8000_010C);
    do_sys("R11 ebreak", 12'h001, 32'h8000_0110);
    do_csr("R11 cause3", 3'd2, 12'h342, 32'h0, 0, 32'h8000_0114);
    do_sys("R11 unknown", 12'h105, 32'h8000_0118);
    do_csr("R11 cause2", 3'd2, 12'h342, 32'h0, 0, 32'h8000_011C);
    do_csr("R11 tval pc", 3'd2, 12'h343, 32'h0, 0, 32'h8000_0120);
    // R10 return into machine mode keeps machine privilege
    do_csr("R4 mstatus pp3", 3'd1, 12'h300, 32'h0000_1800, 0, 32'h8000_0124);
    do_mret("R10 mret machine");
    do_csr("R10 priv kept", 3'd2, 12'h300, 32'h0, 0, 32'h8000_0128);
    // R12 trap and CSR together: trap wins, no write
    @(negedge clk); clear_in();
    begin
      exp_t e;
      csr_req = 1; csr_op = 3'd1; csr_addr = 12'h340; csr_rs1 = 32'h0BAD_0BAD;
      trap_req = 1; trap_cause = 5'd1; pc = 32'h8000_0300;
      e.tag = "R12 trap blocks rd"; e.rdata = ref_read(12'h340); e.chk_rdata = 1;
      e.rd_en = 0; e.redir = 1; e.tgt = m_mtvec; e.priv = m_priv; e.is_cyc = 0;
      sb_q.push_back(e);
      ref_trap(1'b0, 5'd1, 32'h0, 32'h8000_0300);
    end
    do_csr("R12 mscratch kept", 3'd2, 12'h340, 32'h0, 0, 32'h8000_0304);
    // R13 cycle alias
    do_csr("R13 cycle a", 3'd2, 12'hC00, 32'h0, 0, 32'h8000_0308);
    idle(); idle(); idle();
    do_csr("R13 cycle b", 3'd1, 12'hC00, 32'hFFFF_FFFF, 0, 32'h8000_030C);
    do_csr("R13 cycle c", 3'd2, 12'hC00, 32'h0, 0, 32'h8000_0310);
    idle(); idle();

    if (cyc_seen.size() == 3) begin
      vectors++;
      if (cyc_seen[1] - cyc_seen[0] !== 32'd4)
        fail_line("R13 step", "delta", cyc_seen[1] - cyc_seen[0], 32'd4);
      vectors++;
      if (cyc_seen[2] - cyc_seen[1] !== 32'd1)
        fail_line("R13 write ignored", "delta", cyc_seen[2] - cyc_seen[1], 32'd1);
    end else begin
      fail_line("R13", "samples", cyc_seen.size(), 32'd3);
    end

    done = 1;
    summary();
    $finish;
  end
endmodule